// File: doc/BRIEF.md
# NAND Cache-Program Device Engine

This block models the device side of a flash cache-program sequence. Command, address and data bytes arrive on a byte-wide write path that carries a command-latch and an address-latch qualifier. The engine has two stages. The first is a cache register that accepts a page from the host. The second is a page buffer that feeds a simulated array-program timer. When the host confirms a page with the cache code, the engine moves the page into the page buffer as soon as that buffer is free. It then releases the ready/busy line so that the next page can load while the previous one programs.

The array program time, the cache-to-buffer move time and the page size are parameters. Actual cell contents are not stored, so only the page row address and its pass/fail outcome move through the pipeline. A status read returns the array-idle flag, the cache-ready flag and two error flags. One error flag covers the page that completed most recently and the other covers the page that completed before it. A page fails if its row matches an enabled injection address, if it leaves the erase block of the first page in the sequence, or if it is beyond the page limit of one sequence.

Top module: `nand_cache_prog`

## Requirements
- R1: After reset `rb_o` is 1, `io_o` is 0, and a status read returns 0x60.
- R2: Command 0x80 followed by ADDR_CYCLES address writes opens a page load. The first two address writes are column bytes and the rest form the row, least significant byte first. Data writes follow, and writes beyond PAGE_BYTES are ignored.
- R3: Cache confirm code 0x15, when the page buffer is idle, holds `rb_o` low from the cycle after the confirm write until XFER_CYCLES+2 edges after it. `rb_o` then returns to 1 while the array program continues.
- R4: A confirmed page waits in the cache until the pending array program (PROG_CYCLES) has finished. Only then does its XFER_CYCLES move begin, and `rb_o` stays low for the whole wait.
- R5: Last-page code 0x10 holds `rb_o` low until the cache is empty and every pending program has finished. `rb_o` returns to 1 one edge after the last program ends.
- R6: Status bit 6 is 1 when the cache register can accept data. Status bit 5 is 1 only when no array program is running or queued. Bits 7, 4, 3 and 2 read 0.
- R7: When each page finishes programming, status bit 1 takes the old value of bit 0, and bit 0 takes that page's fail result. Both bits clear when the first page of a new sequence is confirmed.
- R8: A page whose row block (row bits above the low log2(PAGES_PER_BLK) bits) differs from the block of the sequence's first page fails.
- R9: Each sequence accepts MAX_PAGES good pages. The (MAX_PAGES+1)-th and later pages fail.
- R10: With `inj_en_i` set, a page confirmed with a row equal to `inj_row_i` fails.
- R11: While `rb_o` is 0, every command except 0x70 is ignored, along with the address and data writes that follow it.
- R12: Command 0x70 drives the status byte on `io_o`. Any other command returns `io_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | One-cycle write strobe for io_i |
| cle_i | input | 1 | Qualifies the write as a command byte |
| ale_i | input | 1 | Qualifies the write as an address byte |
| io_i | input | 8 | Command, address or data byte |
| io_o | output | 8 | Status byte while status is selected, otherwise 0 |
| rb_o | output | 1 | Ready (1) / busy (0) |
| inj_en_i | input | 1 | Enables forced program failure |
| inj_row_i | input | ROW_W | Row address that is forced to fail |

## Verification
The assertions assume the host follows the handshake. It asserts at most one of `cle_i` and `ale_i` per write and issues no confirm unless the engine is ready. The decoder enforces the second condition by rejecting 0x80 while busy, and the confirm-legality property checks it. The bench keeps within these assumptions by waiting for `rb_o` high before each page load. It pulses `we_i` for exactly one cycle with a single qualifier, and it sends stray commands only to test that they are ignored during busy time. Cycle-exact ready times are predicted from the confirm edge and the XFER_CYCLES and PROG_CYCLES parameters.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
  localparam logic [7:0] CMD_LOAD  = 8'h80;
  localparam logic [7:0] CMD_CACHE = 8'h15;
  localparam logic [7:0] CMD_LAST  = 8'h10;
  localparam logic [7:0] CMD_STAT  = 8'h70;

  typedef enum logic [1:0] {
    DEC_IDLE,
    DEC_ADDR,
    DEC_DATA
  } dec_state_e;
endpackage

// File: rtl/nand_cp_dec.sv
module nand_cp_dec
  import nand_cp_pkg::*;
#(
  parameter int ADDR_CYCLES = 4,
  parameter int PAGE_BYTES  = 16,
  parameter int ROW_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       io_i,
  input  logic             busy_i,
  output logic             conf_o,
  output logic             last_o,
  output logic [ROW_W-1:0] row_o,
  output logic             stat_sel_o
);
  localparam int AC_W    = $clog2(ADDR_CYCLES + 1);
  localparam int BC_W    = $clog2(PAGE_BYTES + 1);
  localparam int COL_CYC = ADDR_CYCLES - ROW_W / 8;
  localparam logic [AC_W-1:0] AC_LAST = AC_W'(ADDR_CYCLES - 1);
  localparam logic [AC_W-1:0] AC_COL  = AC_W'(COL_CYC);
  localparam logic [BC_W-1:0] BC_MAX  = BC_W'(PAGE_BYTES);

  dec_state_e      state_q;
  logic [AC_W-1:0] acnt_q;
  logic [BC_W-1:0] bcnt_q;

  wire cmd_wr  = we_i && cle_i;
  wire addr_wr = we_i && ale_i && !cle_i;
  wire data_wr = we_i && !ale_i && !cle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= DEC_IDLE;
      acnt_q     <= '0;
      bcnt_q     <= '0;
      row_o      <= '0;
      conf_o     <= 1'b0;
      last_o     <= 1'b0;
      stat_sel_o <= 1'b0;
    end else begin
      conf_o <= 1'b0;
      last_o <= 1'b0;
      if (cmd_wr) begin
        stat_sel_o <= (io_i == CMD_STAT);
        if (io_i == CMD_LOAD && !busy_i) begin
          state_q <= DEC_ADDR;
          acnt_q  <= '0;
          bcnt_q  <= '0;
        end else if ((io_i == CMD_CACHE || io_i == CMD_LAST) && state_q == DEC_DATA) begin
          conf_o  <= 1'b1;
          last_o  <= (io_i == CMD_LAST);
          state_q <= DEC_IDLE;
        end else if (io_i != CMD_STAT) begin
          state_q <= DEC_IDLE;
        end
      end else if (addr_wr && state_q == DEC_ADDR) begin
        if (acnt_q >= AC_COL) row_o <= {io_i, row_o[ROW_W-1:8]};
        if (acnt_q == AC_LAST) state_q <= DEC_DATA;
        acnt_q <= acnt_q + 1'b1;
      end else if (data_wr && state_q == DEC_DATA && bcnt_q < BC_MAX) begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assert_byte_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= BC_MAX);
  assert_addr_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == DEC_ADDR |-> acnt_q <= AC_LAST);
endmodule

// File: rtl/nand_cp_pipe.sv
module nand_cp_pipe #(
  parameter int PROG_CYCLES   = 40,
  parameter int XFER_CYCLES   = 4,
  parameter int MAX_PAGES     = 64,
  parameter int PAGES_PER_BLK = 64,
  parameter int ROW_W         = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conf_i,
  input  logic             last_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             inj_en_i,
  input  logic [ROW_W-1:0] inj_row_i,
  output logic             busy_o,
  output logic [7:0]       status_o
);
  localparam int PG_W  = $clog2(PAGES_PER_BLK);
  localparam int BLK_W = ROW_W - PG_W;
  localparam int XC_W  = $clog2(XFER_CYCLES) + 1;
  localparam int PC_W  = $clog2(PROG_CYCLES) + 1;
  localparam int SC_W  = $clog2(MAX_PAGES + 2);
  localparam logic [SC_W-1:0] SEQ_CAP = SC_W'(MAX_PAGES);

  logic             cache_full_q, cache_bad_q, last_pend_q;
  logic             xfer_on_q, pb_busy_q, pb_bad_q;
  logic [XC_W-1:0]  xfer_cnt_q;
  logic [PC_W-1:0]  prog_cnt_q;
  logic             seq_on_q;
  logic [BLK_W-1:0] seq_blk_q;
  logic [SC_W-1:0]  seq_cnt_q;
  logic             sr0_q, sr1_q;

  wire [BLK_W-1:0] row_blk = row_i[ROW_W-1:PG_W];
  wire inj_hit    = inj_en_i && (row_i == inj_row_i);
  wire seq_bad    = seq_on_q && (row_blk != seq_blk_q || seq_cnt_q >= SEQ_CAP);
  wire start_xfer = cache_full_q && !xfer_on_q && !pb_busy_q;
  wire xfer_done  = xfer_on_q && xfer_cnt_q == '0;
  wire prog_done  = pb_busy_q && prog_cnt_q == '0;
  wire seq_end    = last_pend_q && !cache_full_q && !pb_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cache_full_q <= 1'b0;
      cache_bad_q  <= 1'b0;
      last_pend_q  <= 1'b0;
      xfer_on_q    <= 1'b0;
      xfer_cnt_q   <= '0;
      pb_busy_q    <= 1'b0;
      pb_bad_q     <= 1'b0;
      prog_cnt_q   <= '0;
      seq_on_q     <= 1'b0;
      seq_blk_q    <= '0;
      seq_cnt_q    <= '0;
      sr0_q        <= 1'b0;
      sr1_q        <= 1'b0;
    end else begin
      if (conf_i) begin
        cache_full_q <= 1'b1;
        cache_bad_q  <= inj_hit || seq_bad;
        if (last_i) last_pend_q <= 1'b1;
        if (!seq_on_q) begin
          seq_on_q  <= 1'b1;
          seq_blk_q <= row_blk;
          seq_cnt_q <= SC_W'(1);
          sr0_q     <= 1'b0;
          sr1_q     <= 1'b0;
        end else if (seq_cnt_q <= SEQ_CAP) begin
          seq_cnt_q <= seq_cnt_q + 1'b1;
        end
      end
      if (start_xfer) begin
        xfer_on_q  <= 1'b1;
        xfer_cnt_q <= XC_W'(XFER_CYCLES - 1);
      end else if (xfer_done) begin
        xfer_on_q    <= 1'b0;
        cache_full_q <= 1'b0;
        pb_busy_q    <= 1'b1;
        pb_bad_q     <= cache_bad_q;
        prog_cnt_q   <= PC_W'(PROG_CYCLES - 1);
      end else if (xfer_on_q) begin
        xfer_cnt_q <= xfer_cnt_q - 1'b1;
      end
      if (prog_done) begin
        pb_busy_q <= 1'b0;
        sr1_q     <= sr0_q;
        sr0_q     <= pb_bad_q;
      end else if (pb_busy_q) begin
        prog_cnt_q <= prog_cnt_q - 1'b1;
      end
      if (seq_end) begin
        last_pend_q <= 1'b0;
        seq_on_q    <= 1'b0;
      end
    end
  end

  assign busy_o   = cache_full_q || last_pend_q;
  assign status_o = {1'b0, !cache_full_q, !(cache_full_q || pb_busy_q), 3'b000, sr1_q, sr0_q};

  assert_confirm_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_i |=> busy_o);
  assert_xfer_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_on_q |-> !pb_busy_q);
  assert_seq_end_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(last_pend_q) |-> !cache_full_q && !pb_busy_q && !xfer_on_q);
  assert_seq_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_cnt_q <= SEQ_CAP + 1'b1);
  assert_confirm_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_i |-> !busy_o);
endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog
  import nand_cp_pkg::*;
#(
  parameter int ADDR_CYCLES   = 4,
  parameter int PAGE_BYTES    = 16,
  parameter int PROG_CYCLES   = 40,
  parameter int XFER_CYCLES   = 4,
  parameter int MAX_PAGES     = 64,
  parameter int PAGES_PER_BLK = 64,
  localparam int ROW_W        = 8 * (ADDR_CYCLES - 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic [7:0]       io_i,
  output logic [7:0]       io_o,
  output logic             rb_o,
  input  logic             inj_en_i,
  input  logic [ROW_W-1:0] inj_row_i
);
  logic             conf, last, stat_sel, busy;
  logic [ROW_W-1:0] row;
  logic [7:0]       status;

  nand_cp_dec #(
    .ADDR_CYCLES(ADDR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W)
  ) u_dec (
    .clk_i, .rst_ni, .we_i, .cle_i, .ale_i, .io_i,
    .busy_i(busy), .conf_o(conf), .last_o(last), .row_o(row), .stat_sel_o(stat_sel)
  );

  nand_cp_pipe #(
    .PROG_CYCLES(PROG_CYCLES), .XFER_CYCLES(XFER_CYCLES), .MAX_PAGES(MAX_PAGES),
    .PAGES_PER_BLK(PAGES_PER_BLK), .ROW_W(ROW_W)
  ) u_pipe (
    .clk_i, .rst_ni, .conf_i(conf), .last_i(last), .row_i(row),
    .inj_en_i, .inj_row_i, .busy_o(busy), .status_o(status)
  );

  assign rb_o = !busy;
  assign io_o = stat_sel ? status : 8'h00;

  assert_io_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_sel |-> io_o == 8'h00);
endmodule

// File: tb/nand_cache_prog_test.sv
`timescale 1ns/1ps
module nand_cache_prog_test;
  localparam int AC = 4;
  localparam int PB = 16;
  localparam int P  = 40;
  localparam int X  = 4;
  localparam int MP = 64;
  localparam int RW = 8 * (AC - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 0, cle = 0, ale = 0, inj_en = 0;
  logic [7:0] io = 8'h00;
  logic [RW-1:0] inj_row = '0;
  logic [7:0] io_out;
  logic rb;
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_cache_prog #(.ADDR_CYCLES(AC), .PAGE_BYTES(PB), .PROG_CYCLES(P),
                    .XFER_CYCLES(X), .MAX_PAGES(MP), .PAGES_PER_BLK(64)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .cle_i(cle), .ale_i(ale), .io_i(io),
    .io_o(io_out), .rb_o(rb), .inj_en_i(inj_en), .inj_row_i(inj_row));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; we = 1'b1; io = d;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0; io = 8'h00;
  endtask

  task automatic wait_ready(output int t);
    while (!rb) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic read_status(output int s);
    wr(1, 0, 8'h70);
    s = io_out;
  endtask

  // returns edge index of the confirm write
  task automatic load_page(input logic [RW-1:0] row, input int nbytes,
                           input logic [7:0] cmd, output int c);
    wr(1, 0, 8'h80);
    wr(0, 1, 8'h00);
    wr(0, 1, 8'h00);
    for (int i = 0; i < RW / 8; i++) wr(0, 1, row[8*i +: 8]);
    for (int i = 0; i < nbytes; i++) wr(0, 0, 8'(i));
    wr(1, 0, cmd);
    c = cyc;
  endtask

  task automatic t_reset();
    int s;
    check("R1 rb after reset", rb, 1);
    check("R1 io idle", io_out, 0);
    read_status(s);
    check("R1 status after reset", s, 8'h60);
    wr(1, 0, 8'hFF);
    check("R12 io cleared by other command", io_out, 0);
  endtask

  task automatic t_single_last();
    int c, s, t;
    load_page(16'h0100, PB + 3, 8'h10, c);
    read_status(s);
    check("R6 status while cache full", s, 8'h00);
    check("R5 busy after last confirm", rb, 0);
    wait_until(c + X + 4);
    s = io_out;
    check("R6 status while programming", s, 8'h40);
    check("R5 busy during last program", rb, 0);
    wait_ready(t);
    check("R5 ready time single last page", t - c, X + P + 3);
    read_status(s);
    check("R2 page accepted without error", s, 8'h60);
  endtask

  task automatic t_pipeline();
    int ca, cb, cc, s, t;
    load_page(16'h0200, 4, 8'h15, ca);
    @(negedge clk);
    check("R3 busy after cache confirm", rb, 0);
    wait_ready(t);
    check("R3 cache confirm busy length", t - ca, X + 2);
    read_status(s);
    check("R6 cache ready, array busy", s, 8'h40);
    load_page(16'h0201, 4, 8'h15, cb);
    @(negedge clk);
    check("R4 second page waits", rb, 0);
    wait_ready(t);
    check("R4 ready after pending program", t - ca, 2 * X + P + 3);
    load_page(16'h0202, 4, 8'h10, cc);
    @(negedge clk);
    wait_ready(t);
    check("R5 ready after all programs", t - ca, 3 * X + 3 * P + 5);
    read_status(s);
    check("R7 clean three-page sequence", s, 8'h60);
  endtask

  task automatic t_inject();
    int c, s, t;
    inj_en = 1'b1; inj_row = 16'h0041;
    wait_ready(t);
    load_page(16'h0040, 2, 8'h15, c); @(negedge clk); wait_ready(t);
    load_page(16'h0041, 2, 8'h15, c); @(negedge clk); wait_ready(t);
    load_page(16'h0042, 2, 8'h10, c); @(negedge clk); wait_ready(t);
    read_status(s);
    check("R10 R7 fail moves to previous-page bit", s, 8'h62);
    inj_row = 16'h0080;
    load_page(16'h0080, 2, 8'h10, c); @(negedge clk); wait_ready(t);
    read_status(s);
    check("R10 single-page forced fail", s, 8'h61);
    inj_en = 1'b0;
    load_page(16'h0080, 2, 8'h10, c); @(negedge clk); wait_ready(t);
    read_status(s);
    check("R7 error bits cleared at new sequence", s, 8'h60);
  endtask

  task automatic t_block();
    int c, s, t;
    load_page(16'h00C0, 2, 8'h15, c); @(negedge clk); wait_ready(t);
    load_page(16'h0100, 2, 8'h10, c); @(negedge clk); wait_ready(t);
    read_status(s);
    check("R8 page outside start block fails", s, 8'h61);
  endtask

  task automatic run_seq(input int n, output int s);
    int c, t;
    for (int i = 0; i < n; i++) begin
      load_page(RW'(16'h0080 + (i % 64)), 2, (i == n - 1) ? 8'h10 : 8'h15, c);
      @(negedge clk);
      wait_ready(t);
    end
    read_status(s);
  endtask

  task automatic t_limit();
    int s;
    run_seq(MP, s);
    check("R9 full sequence of MAX_PAGES passes", s, 8'h60);
    run_seq(MP + 1, s);
    check("R9 page beyond limit fails", s, 8'h61);
  endtask

  task automatic t_busy_ignore();
    int c, s, t, lows;
    load_page(16'h0300, 2, 8'h10, c);
    wr(1, 0, 8'h80);
    wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(0, 1, 8'h05); wr(0, 1, 8'h03);
    wr(0, 0, 8'hAA);
    wr(1, 0, 8'h15);
    check("R11 still busy with stray commands", rb, 0);
    wait_ready(t);
    check("R11 ready time unaffected", t - c, X + P + 3);
    lows = 0;
    for (int i = 0; i < 2 * (X + 2); i++) begin
      @(negedge clk);
      if (!rb) lows++;
    end
    check("R11 ignored confirm starts nothing", lows, 0);
    read_status(s);
    check("R11 status after ignored load", s, 8'h60);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_last();
    t_pipeline();
    t_inject();
    t_block();
    t_limit();
    t_busy_ignore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule